// File: doc/BRIEF.md
# Watchdog Timer with Alternating-Clear Protection

This block guards a processor against runaway software. A free-running prescaler divides the watchdog clock by a power of two picked by a 3-bit select. Its output ticks an 8-bit main counter. When the main counter wraps, the block raises a one-cycle request and sets a sticky time-out flag. The request is a full device reset when the core is awake, or a wake-up that restarts only the program counter and stack pointer when the core is asleep.

Software keeps the watchdog quiet by clearing it in time. A configuration bit picks one of two clear schemes. In the first, a single clear strobe is enough. In the second, the clear only counts when the two clear strobes alternate, so a loop that repeats one clear forever cannot keep the watchdog silent.

The watchdog is switched off only by one 4-bit code together with a cleared hard-enable bit. Any other code leaves it running. An external reset or a halt also restarts the count. The clock-source selection and the processor are outside the block. All pins are plain control and status levels or strobes, so the block has no valid/ready stream and no back-pressure.

Top module: `wdg_guard`

## Requirements
- R1: The watchdog runs when `cfg_force_on` is 1 or when `en_code` differs from 4'b1010. With `cfg_force_on`=0 and `en_code`=4'b1010 it is stopped. While stopped it raises no request and `to_flag` does not change. The recommended run code is 4'b0101.
- R2: The time-out period is 256·2^N enabled clock edges, counted from the edge that restarts the count (or from the first enabled edge). N is `div_sel`, so 3'b111 gives the longest period of 32768 edges.
- R3: When the period expires while `sleep`=0, `rst_req` is high for exactly one cycle after that edge and `wake_req` stays low.
- R4: When the period expires while `sleep`=1, `wake_req` is high for exactly one cycle and `rst_req` stays low.
- R5: `to_flag` sets on any expiry. Only `por_n` low clears it.
- R6: `ext_rst` or `halt` high at an enabled edge restarts the count in either clear scheme. `ext_rst` also forgets the last alternate clear seen.
- R7: With `cfg_pair_mode`=0, `clr_single` restarts the count, and `clr_a` and `clr_b` have no effect.
- R8: With `cfg_pair_mode`=1, `clr_a` restarts the count only when the last alternate clear seen was `clr_b`, and `clr_b` restarts it only when the last one was `clr_a`. Repeating a strobe, raising both in the same cycle, or raising `clr_single` has no effect.
- R9: While stopped, the count stays at zero and all clear, halt and reset strobes are ignored. The memory of the last alternate clear is dropped, so the first alternate clear after re-enabling does not restart the count.
- R10: While `por_n` is low, all outputs are 0. Counting starts from zero after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| cfg_force_on | input | 1 | Hard enable; 1 keeps the watchdog running |
| cfg_pair_mode | input | 1 | 0: single clear scheme, 1: alternating clear scheme |
| en_code | input | 4 | Software enable code; 4'b1010 means off |
| div_sel | input | 3 | Prescaler select N, ratio 2^N |
| sleep | input | 1 | Core is in sleep or idle |
| ext_rst | input | 1 | External reset strobe |
| halt | input | 1 | Halt instruction strobe |
| clr_single | input | 1 | Single clear strobe |
| clr_a | input | 1 | First alternate clear strobe |
| clr_b | input | 1 | Second alternate clear strobe |
| rst_req | output | 1 | One-cycle full device reset request |
| wake_req | output | 1 | One-cycle wake request that restarts PC and stack pointer |
| to_flag | output | 1 | Sticky time-out status |

## Verification
The assertions assume that every input is synchronous to `clk` and has a defined value from time zero. They also assume that `div_sel` changes only together with a restart or while the watchdog is stopped, so that each period is counted at one ratio. The random stimulus keeps to this: it alters `div_sel` and `cfg_pair_mode` only in the same cycle as an `ext_rst` pulse. Most runs use ratios 1 and 2 so that many expiries occur. One directed run covers the longest ratio to its exact edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // Memory of the most recent alternate clear strobe
  typedef enum logic [1:0] {
    PAIR_NONE = 2'd0,
    PAIR_A    = 2'd1,
    PAIR_B    = 2'd2
  } pair_last_e;
endpackage

// File: rtl/wdg_enable_dec.sv
module wdg_enable_dec #(
  parameter int unsigned CODE_W = 4,
  parameter logic [CODE_W-1:0] OFF_CODE = 4'b1010
) (
  input  logic              force_on,
  input  logic [CODE_W-1:0] code,
  output logic              run
);
  // Only the exact off code, with no hard enable, stops the watchdog
  always_comb begin
    run = force_on || (code != OFF_CODE);
  end
endmodule

// File: rtl/wdg_clear_ctl.sv
module wdg_clear_ctl
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic pair_mode,
  input  logic ext_rst,
  input  logic halt,
  input  logic clr_single,
  input  logic clr_a,
  input  logic clr_b,
  output logic restart
);
  pair_last_e last_q, last_d;
  logic a_only, b_only, sw_clr;

  always_comb begin
    a_only = clr_a && !clr_b;
    b_only = clr_b && !clr_a;
    if (pair_mode)
      sw_clr = (a_only && last_q == PAIR_B) || (b_only && last_q == PAIR_A);
    else
      sw_clr = clr_single;
    restart = run && (ext_rst || halt || sw_clr);
  end

  always_comb begin
    last_d = last_q;
    if (!run || ext_rst || !pair_mode) last_d = PAIR_NONE;
    else if (a_only)                   last_d = PAIR_A;
    else if (b_only)                   last_d = PAIR_B;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) last_q <= PAIR_NONE;
    else        last_q <= last_d;
  end

  // R8: a repeated first alternate clear never restarts the count
  a_r8_repeat_a_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (run && pair_mode && a_only && last_q == PAIR_A && !ext_rst && !halt) |-> !restart);
  // R8: a repeated second alternate clear never restarts the count
  a_r8_repeat_b_ignored: assert property (@(posedge clk) disable iff (!por_n)
    (run && pair_mode && b_only && last_q == PAIR_B && !ext_rst && !halt) |-> !restart);
  // R9: history is forgotten while stopped
  a_r9_history_drop: assert property (@(posedge clk) disable iff (!por_n)
    !run |=> (last_q == PAIR_NONE));
  // R6: external reset forgets history
  a_r6_ext_forgets: assert property (@(posedge clk) disable iff (!por_n)
    ext_rst |=> (last_q == PAIR_NONE));
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned PRE_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // The low N bits of the mask are ones: a tick every 2^N edges
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (int'(sel) > i);
  end

  assign tick = run && !restart && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                pre_q <= '0;
    else if (!run || restart)  pre_q <= '0;
    else                       pre_q <= pre_q + PRE_W'(1);
  end

  // R9: prescaler is parked while stopped
  a_r9_pre_parked: assert property (@(posedge clk) disable iff (!por_n)
    !run |=> (pre_q == '0));
  // R6: a restart zeroes the prescaler
  a_r6_pre_restart: assert property (@(posedge clk) disable iff (!por_n)
    restart |=> (pre_q == '0));
endmodule

// File: rtl/wdg_main_cnt.sv
module wdg_main_cnt #(
  parameter int unsigned MAIN_W = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic wrap
);
  logic [MAIN_W-1:0] cnt_q;

  assign wrap = tick && (cnt_q == {MAIN_W{1'b1}});

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cnt_q <= '0;
    else if (!run || restart) cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_q + MAIN_W'(1);
  end

  // R9: main counter holds zero while stopped
  a_r9_cnt_parked: assert property (@(posedge clk) disable iff (!por_n)
    !run |=> (cnt_q == '0));
  // R6: a restart zeroes the main counter
  a_r6_cnt_restart: assert property (@(posedge clk) disable iff (!por_n)
    restart |=> (cnt_q == '0));
  // R2: the counter never moves without a prescaler tick
  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!por_n)
    (run && !restart && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard #(
  parameter int unsigned CODE_W = 4,
  parameter logic [CODE_W-1:0] OFF_CODE = 4'b1010,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned MAIN_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cfg_force_on,
  input  logic              cfg_pair_mode,
  input  logic [CODE_W-1:0] en_code,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              sleep,
  input  logic              ext_rst,
  input  logic              halt,
  input  logic              clr_single,
  input  logic              clr_a,
  input  logic              clr_b,
  output logic              rst_req,
  output logic              wake_req,
  output logic              to_flag
);
  logic run, restart, tick, wrap;

  wdg_enable_dec #(.CODE_W(CODE_W), .OFF_CODE(OFF_CODE)) u_en (
    .force_on (cfg_force_on),
    .code     (en_code),
    .run      (run)
  );

  wdg_clear_ctl u_clr (
    .clk        (clk),
    .por_n      (por_n),
    .run        (run),
    .pair_mode  (cfg_pair_mode),
    .ext_rst    (ext_rst),
    .halt       (halt),
    .clr_single (clr_single),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .restart    (restart)
  );

  wdg_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .por_n   (por_n),
    .run     (run),
    .restart (restart),
    .sel     (div_sel),
    .tick    (tick)
  );

  wdg_main_cnt #(.MAIN_W(MAIN_W)) u_cnt (
    .clk     (clk),
    .por_n   (por_n),
    .run     (run),
    .restart (restart),
    .tick    (tick),
    .wrap    (wrap)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      rst_req  <= wrap && !sleep;
      wake_req <= wrap && sleep;
      to_flag  <= to_flag || wrap;
    end
  end

  // R3/R4: at most one request at a time
  a_r3_one_request: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({rst_req, wake_req}));
  // R3: a reset request only follows an awake edge
  a_r3_awake_reset: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> !$past(sleep));
  // R4: a wake request only follows a sleeping edge
  a_r4_sleep_wake: assert property (@(posedge clk) disable iff (!por_n)
    wake_req |-> $past(sleep));
  // R3: the reset request is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);
  // R5: the time-out flag is sticky
  a_r5_to_sticky: assert property (@(posedge clk) disable iff (!por_n)
    to_flag |=> to_flag);
  // R5: every request is accompanied by the flag
  a_r5_to_with_req: assert property (@(posedge clk) disable iff (!por_n)
    (rst_req || wake_req) |-> to_flag);
  // R1: a stopped watchdog stays quiet
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!por_n)
    !run |=> (!rst_req && !wake_req));
endmodule

// File: tb/sim_wdg_guard.sv
module sim_wdg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 200000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       por_n = 1'b0, cfg_force_on = 1'b0, cfg_pair_mode = 1'b0, sleep = 1'b0;
  logic       ext_rst = 1'b0, halt = 1'b0, clr_single = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
  logic [3:0] en_code = 4'b1010;
  logic [2:0] div_sel = 3'd0;
  logic       rst_req, wake_req, to_flag;

  wdg_guard u0 (
    .clk(clk), .por_n(por_n), .cfg_force_on(cfg_force_on), .cfg_pair_mode(cfg_pair_mode),
    .en_code(en_code), .div_sel(div_sel), .sleep(sleep), .ext_rst(ext_rst), .halt(halt),
    .clr_single(clr_single), .clr_a(clr_a), .clr_b(clr_b),
    .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag)
  );

  int    checks = 0, errors = 0;
  string phase = "R10";
  int    since = 0, last = 0;
  bit    m_to = 0, m_rst = 0, m_wake = 0;
  bit    done = 0;

  function automatic int period(input logic [2:0] n);
    return 256 << n;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  // Expected behaviour taken from the requirements, one enabled edge at a time
  task automatic model();
    bit en, a1, b1, sw, clr;
    m_rst = 0; m_wake = 0;
    if (!por_n) begin
      since = 0; last = 0; m_to = 0;
      return;
    end
    en = cfg_force_on || (en_code != 4'b1010);
    if (!en) begin
      since = 0; last = 0;
      return;
    end
    a1 = clr_a && !clr_b;
    b1 = clr_b && !clr_a;
    sw = cfg_pair_mode ? ((a1 && last == 2) || (b1 && last == 1)) : clr_single;
    clr = ext_rst || halt || sw;
    if (ext_rst || !cfg_pair_mode) last = 0;
    else if (a1) last = 1;
    else if (b1) last = 2;
    if (clr) since = 0;
    else begin
      since++;
      if (since == period(div_sel)) begin
        since = 0;
        if (sleep) m_wake = 1; else m_rst = 1;
        m_to = 1;
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model();
    @(negedge clk);
    chk(phase, "rst_req", int'(rst_req), int'(m_rst));
    chk(phase, "wake_req", int'(wake_req), int'(m_wake));
    chk(phase, "to_flag", int'(to_flag), int'(m_to));
  endtask

  task automatic run(input int n);
    repeat (n) cyc();
  endtask

  // order: ext_rst, halt, clr_single, clr_a, clr_b
  task automatic fire(input logic [4:0] s);
    {ext_rst, halt, clr_single, clr_a, clr_b} = s;
    cyc();
    {ext_rst, halt, clr_single, clr_a, clr_b} = 5'b0;
  endtask

  task automatic por();
    por_n = 1'b0;
    cyc();
    chk(phase, "to_flag after por", int'(to_flag), 0);
    por_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    phase = "R10 reset";
    run(3);
    chk("R10", "rst_req in reset", int'(rst_req), 0);
    por_n = 1'b1;

    phase = "R1 off code";
    run(600);
    chk("R1", "to_flag while off", int'(to_flag), 0);
    en_code = 4'b0101;
    phase = "R1 run code";
    run(300);
    chk("R1", "to_flag after run code", int'(to_flag), 1);
    en_code = 4'b1010; cfg_force_on = 1'b1;
    phase = "R1 forced";
    por();
    run(300);
    chk("R1", "to_flag forced on", int'(to_flag), 1);

    phase = "R5 por clears";
    por();
    phase = "R4 sleep";
    sleep = 1'b1;
    fire(5'b10000);
    run(260);
    sleep = 1'b0;

    phase = "R2 longest";
    div_sel = 3'd7;
    fire(5'b10000);
    run(period(3'd7) - 1);
    chk("R2", "rst_req one edge early", int'(rst_req), 0);
    cyc();
    chk("R2", "rst_req at 32768", int'(rst_req), 1);
    div_sel = 3'd0;
    fire(5'b10000);

    phase = "R7 single";
    cfg_pair_mode = 1'b0;
    por();
    for (int i = 0; i < 6; i++) begin
      run(200);
      fire(5'b00100);
    end
    chk("R7", "to_flag with single clears", int'(to_flag), 0);
    for (int i = 0; i < 4; i++) begin
      run(100);
      fire(5'b00010);
      run(100);
      fire(5'b00001);
    end
    chk("R7", "to_flag with ignored alternates", int'(to_flag), 1);

    phase = "R8 pair";
    cfg_pair_mode = 1'b1;
    por();
    for (int i = 0; i < 6; i++) begin
      fire(5'b00010);
      run(100);
      fire(5'b00001);
      run(100);
    end
    chk("R8", "to_flag alternating", int'(to_flag), 0);
    for (int i = 0; i < 5; i++) begin
      fire(5'b00010);
      run(100);
    end
    chk("R8", "to_flag repeated clr_a", int'(to_flag), 1);
    por();
    fire(5'b00010);
    for (int i = 0; i < 4; i++) begin
      run(100);
      fire(5'b00111);
    end
    chk("R8", "to_flag both and single", int'(to_flag), 1);

    phase = "R9 disabled";
    cfg_force_on = 1'b0;
    por();
    en_code = 4'b1010;
    fire(5'b00010);
    fire(5'b01100);
    run(300);
    chk("R9", "to_flag while stopped", int'(to_flag), 0);
    en_code = 4'b0101;
    run(50);
    fire(5'b00001);
    run(250);
    chk("R9", "to_flag after re-enable", int'(to_flag), 1);

    phase = "R6 halt ext";
    por();
    for (int i = 0; i < 5; i++) begin
      run(200);
      fire(5'b01000);
    end
    chk("R6", "to_flag with halts", int'(to_flag), 0);
    fire(5'b00010);
    fire(5'b10000);
    run(50);
    fire(5'b00001);
    run(250);
    chk("R6", "to_flag ext forgets history", int'(to_flag), 1);

    phase = "R3 random";
    for (int i = 0; i < 30000; i++) begin
      ext_rst    = ($urandom_range(0, 999) < 2);
      if (ext_rst) begin
        div_sel       = 3'($urandom_range(0, 1));
        cfg_pair_mode = 1'($urandom_range(0, 1));
      end
      halt       = ($urandom_range(0, 999) < 2);
      clr_single = ($urandom_range(0, 999) < 4);
      clr_a      = ($urandom_range(0, 999) < 4);
      clr_b      = ($urandom_range(0, 999) < 4);
      if ($urandom_range(0, 999) < 3) sleep = ~sleep;
      if ($urandom_range(0, 999) < 2)
        en_code = ($urandom_range(0, 1) == 0) ? 4'b1010 : 4'($urandom_range(0, 15));
      if ($urandom_range(0, 999) < 1) cfg_force_on = ~cfg_force_on;
      por_n = ($urandom_range(0, 9999) != 0);
      cyc();
    end
    {ext_rst, halt, clr_single, clr_a, clr_b} = 5'b0;
    por_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule